// File: doc/BRIEF.md
# Serial Expander Reset Sequencer

This block drives an external 8-bit shift register with a latched output stage. It uses three lines: a serial data line, a shift clock and a latch clock. A one-cycle start pulse begins a fixed sequence of two frames. The block shifts out each frame bit by bit and latches it before the next frame begins.

Each output of the external register has a role: reset, enable or disable. The first frame turns the enables on and holds every reset-type output low. The second frame keeps the enables on and releases the resets. Reset-type peripherals therefore leave reset only after their supplies and enables have been applied.

All timing comes from one delay interval. It is a parameter counted in system clock cycles; about 500 microseconds is the nominal figure. The role of each output comes from a parameter, so a different board wiring needs no change to the logic.

Top module: `serial_expander_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the shift clock, latch clock, data line and done output are all low.
- R2: Each bit takes two delay intervals. For the first interval the shift clock is low with the data line already at the bit value. For the second interval the shift clock is high and the data line is unchanged. Within a frame the highest-indexed output (Q7) is sent first and Q0 last.
- R3: In the first frame, outputs with a reset role or a disable role are sent as 0, and outputs with an enable role are sent as 1. With the default role map (Q0 disable, Q1..Q5 reset, Q6..Q7 enable) the latched byte is 8'hC0.
- R4: In the second frame, outputs with a reset role or an enable role are sent as 1, and outputs with a disable role are sent as 0. With the default map the latched byte is 8'hFE.
- R5: After the last bit of a frame, the latch clock is low for one delay interval and then rises. The first frame is latched before the first bit of the second frame is driven. Each sequence produces exactly two latch rising edges.
- R6: The done output is high for exactly one cycle. That cycle is the one in which the second-frame latch edge rises, 2*(2*8+1)*D cycles after the clock edge that accepts the start pulse (D is the delay interval). The block then idles with the shift clock high, the latch clock high and the data line low.
- R7: A start pulse that arrives while a sequence is running does not change the waveform or its length, and does not begin another sequence.
- R8: The role map is a parameter with 2 bits per output; output i uses bits [2i+1:2i]. Code 0 means reset, 1 means enable, and 2 or 3 means disable. Changing the map changes both frames with no change to the logic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run the two-frame sequence |
| ser_data_o | output | 1 | Serial data to the external register |
| shift_clk_o | output | 1 | Shift clock; the external register samples data on its rising edge |
| latch_clk_o | output | 1 | Latch clock; its rising edge moves shifted data to the outputs |
| done_o | output | 1 | One-cycle pulse when the second frame has been latched |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a running sequence. The case that matters most is a start pulse in the very last cycle before the final latch edge, when the block is about to return to idle. The bench places one such pulse in that last cycle. It also places pulses at random points during other runs. It then compares every cycle of the three serial lines and the done output against a waveform computed from the cycle index. A second instance with a scrambled role map, including the spare code, runs next to the default instance. A model of the external register captures both latched bytes from each instance.

// File: rtl/serexp_pkg.sv
package serexp_pkg;

    typedef enum logic [1:0] {
        ROLE_RESET   = 2'd0,
        ROLE_ENABLE  = 2'd1,
        ROLE_DISABLE = 2'd2,
        ROLE_SPARE   = 2'd3
    } role_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_BIT_LO,
        PH_BIT_HI,
        PH_LATCH_LO
    } phase_e;

    typedef struct packed {
        logic shift_clk;
        logic latch_clk;
        logic data;
    } pins_t;

    // Level of one output in the hold frame (second = 0) or the release frame (second = 1).
    function automatic logic role_level(input logic [1:0] code, input logic second);
        case (role_e'(code))
            ROLE_RESET:  return second;
            ROLE_ENABLE: return 1'b1;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/serexp_timer.sv
module serexp_timer #(
    parameter int DELAY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DELAY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/serexp_pattern.sv
module serexp_pattern #(
    parameter int                      NUM_BITS = 8,
    parameter logic [2*NUM_BITS-1:0]   ROLE_MAP = 16'h5002
) (
    output logic [NUM_BITS-1:0] hold_pat,
    output logic [NUM_BITS-1:0] release_pat
);
    import serexp_pkg::*;

    for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
        assign hold_pat[i]    = role_level(ROLE_MAP[2*i +: 2], 1'b0);
        assign release_pat[i] = role_level(ROLE_MAP[2*i +: 2], 1'b1);
    end

endmodule

// File: rtl/serial_expander_seq.sv
module serial_expander_seq #(
    parameter int                    NUM_BITS     = 8,
    parameter int                    DELAY_CYCLES = 50000,
    parameter logic [2*NUM_BITS-1:0] ROLE_MAP     = 16'h5002
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic ser_data_o,
    output logic shift_clk_o,
    output logic latch_clk_o,
    output logic done_o
);
    import serexp_pkg::*;

    localparam int                IDX_W   = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1;
    localparam logic [IDX_W-1:0]  IDX_TOP = IDX_W'(NUM_BITS - 1);

    phase_e              phase_q;
    pins_t               pins_q;
    logic                frame_q;
    logic [IDX_W-1:0]    idx_q;
    logic [IDX_W-1:0]    idx_nxt;
    logic                done_q;
    logic                expired;
    logic                advance;
    logic                load;
    logic [NUM_BITS-1:0] hold_pat;
    logic [NUM_BITS-1:0] release_pat;
    logic [NUM_BITS-1:0] cur_pat;

    serexp_pattern #(
        .NUM_BITS (NUM_BITS),
        .ROLE_MAP (ROLE_MAP)
    ) u_pattern (
        .hold_pat    (hold_pat),
        .release_pat (release_pat)
    );

    serexp_timer #(
        .DELAY_CYCLES (DELAY_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .expired (expired)
    );

    always_comb begin
        advance = (phase_q != PH_IDLE) && expired;
        load    = advance || ((phase_q == PH_IDLE) && start_i);
        cur_pat = frame_q ? release_pat : hold_pat;
        idx_nxt = idx_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            pins_q  <= '0;
            frame_q <= 1'b0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q          <= PH_BIT_LO;
                        frame_q          <= 1'b0;
                        idx_q            <= IDX_TOP;
                        pins_q.shift_clk <= 1'b0;
                        pins_q.data      <= hold_pat[IDX_TOP];
                    end
                end
                PH_BIT_LO: begin
                    if (advance) begin
                        phase_q          <= PH_BIT_HI;
                        pins_q.shift_clk <= 1'b1;
                    end
                end
                PH_BIT_HI: begin
                    if (advance) begin
                        if (idx_q == '0) begin
                            phase_q          <= PH_LATCH_LO;
                            pins_q.latch_clk <= 1'b0;
                        end else begin
                            phase_q          <= PH_BIT_LO;
                            idx_q            <= idx_nxt;
                            pins_q.shift_clk <= 1'b0;
                            pins_q.data      <= cur_pat[idx_nxt];
                        end
                    end
                end
                PH_LATCH_LO: begin
                    if (advance) begin
                        pins_q.latch_clk <= 1'b1;
                        if (!frame_q) begin
                            phase_q          <= PH_BIT_LO;
                            frame_q          <= 1'b1;
                            idx_q            <= IDX_TOP;
                            pins_q.shift_clk <= 1'b0;
                            pins_q.data      <= release_pat[IDX_TOP];
                        end else begin
                            phase_q     <= PH_IDLE;
                            pins_q.data <= 1'b0;
                            done_q      <= 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign ser_data_o  = pins_q.data;
    assign shift_clk_o = pins_q.shift_clk;
    assign latch_clk_o = pins_q.latch_clk;
    assign done_o      = done_q;

endmodule

// File: rtl/serexp_checks.sv
module serexp_checks #(
    parameter int NUM_BITS     = 8,
    parameter int DELAY_CYCLES = 4
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic ser_data_o,
    input logic shift_clk_o,
    input logic latch_clk_o,
    input logic done_o
);
    localparam logic [31:0] TOTAL = 32'(2 * (2 * NUM_BITS + 1) * DELAY_CYCLES);

    logic        act_q;
    logic [31:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (!act_q && start_i) begin
            act_q <= 1'b1;
            cnt_q <= '0;
        end else if (act_q && done_o) begin
            act_q <= 1'b0;
        end else if (act_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    rst_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!shift_clk_o && !latch_clk_o && !ser_data_o && !done_o));

    // R2
    data_stable_on_shift_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(shift_clk_o) |-> $stable(ser_data_o));

    // R5
    latch_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_clk_o) |-> (shift_clk_o && $stable(shift_clk_o)));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    done_with_latch_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $rose(latch_clk_o));

    // R7
    seq_length_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (act_q && cnt_q == TOTAL));

endmodule

bind serial_expander_seq serexp_checks #(
    .NUM_BITS     (NUM_BITS),
    .DELAY_CYCLES (DELAY_CYCLES)
) u_serexp_checks (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .ser_data_o  (ser_data_o),
    .shift_clk_o (shift_clk_o),
    .latch_clk_o (latch_clk_o),
    .done_o      (done_o)
);

// File: tb/test_serial_expander_seq.sv
module test_serial_expander_seq;

    localparam int          CLK_PERIOD = 10;
    localparam int          DLY        = 4;
    localparam int          FRAME      = 17 * DLY;
    localparam int          TOTAL      = 2 * FRAME;
    localparam logic [15:0] MAP_DEF    = 16'h5002;
    localparam logic [15:0] MAP_ALT    = 16'h186D;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic d_a, sh_a, la_a, dn_a;
    logic d_b, sh_b, la_b, dn_b;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_expander_seq #(.NUM_BITS(8), .DELAY_CYCLES(DLY), .ROLE_MAP(MAP_DEF)) i_serial_expander_seq (
        .clk(clk), .rst(rst), .start_i(start),
        .ser_data_o(d_a), .shift_clk_o(sh_a), .latch_clk_o(la_a), .done_o(dn_a));

    serial_expander_seq #(.NUM_BITS(8), .DELAY_CYCLES(DLY), .ROLE_MAP(MAP_ALT)) i_serial_expander_seq_alt (
        .clk(clk), .rst(rst), .start_i(start),
        .ser_data_o(d_b), .shift_clk_o(sh_b), .latch_clk_o(la_b), .done_o(dn_b));

    // Model of the external shift-and-latch register, one per instance
    logic [7:0] sr_a = '0, sr_b = '0, q_a = '0, q_b = '0;
    logic [7:0] log_a [0:3];
    logic [7:0] log_b [0:3];
    int lat_a = 0, lat_b = 0;

    always @(posedge sh_a) sr_a <= {sr_a[6:0], d_a};
    always @(posedge sh_b) sr_b <= {sr_b[6:0], d_b};
    always @(posedge la_a) begin
        q_a = sr_a;
        if (lat_a < 4) log_a[lat_a] = sr_a;
        lat_a++;
    end
    always @(posedge la_b) begin
        q_b = sr_b;
        if (lat_b < 4) log_b[lat_b] = sr_b;
        lat_b++;
    end

    function automatic logic [7:0] pat_of(input logic [15:0] map, input logic second);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) begin
            case (map[2*i +: 2])
                2'd0:    p[i] = second;
                2'd1:    p[i] = 1'b1;
                default: p[i] = 1'b0;
            endcase
        end
        return p;
    endfunction

    // {shift, latch, data, done} expected j cycles after the accepting edge
    function automatic logic [3:0] exp_at(input int j, input logic [7:0] p0, input logic [7:0] p1,
                                          input logic lat0);
        int f, r, b;
        logic lat, h;
        logic [7:0] pf;
        if (j >= TOTAL) return {1'b1, 1'b1, 1'b0, (j == TOTAL)};
        f   = j / FRAME;
        r   = j % FRAME;
        pf  = (f != 0) ? p1 : p0;
        lat = (f != 0) ? 1'b1 : lat0;
        if (r < 16 * DLY) begin
            b = 7 - r / (2 * DLY);
            h = ((r % (2 * DLY)) >= DLY);
            return {h, lat, pf[b], 1'b0};
        end
        return {1'b1, 1'b0, pf[0], 1'b0};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic cmp_pins(input int j, input logic [3:0] act, input logic [3:0] e, input string who);
        string dtag;
        dtag = (j < FRAME) ? "R3 data" : "R4 data";
        check($sformatf("R2 shift %s j=%0d", who, j), 8'(act[3]), 8'(e[3]));
        check($sformatf("R5 latch %s j=%0d", who, j), 8'(act[2]), 8'(e[2]));
        check($sformatf("%s %s j=%0d", dtag, who, j), 8'(act[1]), 8'(e[1]));
        check($sformatf("R6 done %s j=%0d", who, j), 8'(act[0]), 8'(e[0]));
    endtask

    task automatic run_seq(input int inj, input logic lat0);
        logic [7:0] pa0, pa1, pb0, pb1;
        pa0 = pat_of(MAP_DEF, 1'b0);
        pa1 = pat_of(MAP_DEF, 1'b1);
        pb0 = pat_of(MAP_ALT, 1'b0);
        pb1 = pat_of(MAP_ALT, 1'b1);
        lat_a = 0;
        lat_b = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int j = 0; j <= TOTAL + 1; j++) begin
            if (j > 0) @(negedge clk);
            cmp_pins(j, {sh_a, la_a, d_a, dn_a}, exp_at(j, pa0, pa1, lat0), "def");
            // R8: scrambled map including the spare code
            cmp_pins(j, {sh_b, la_b, d_b, dn_b}, exp_at(j, pb0, pb1, lat0), "R8 alt");
            start = (j == inj);
        end
        start = 1'b0;
        check("R5 latch edges per run", 8'(lat_a), 8'd2);
        check("R3 first latched byte", log_a[0], 8'hC0);
        check("R4 second latched byte", log_a[1], 8'hFE);
        check("R4 outputs after run", q_a, 8'hFE);
        check("R8 alt first byte", log_b[0], pb0);
        check("R8 alt second byte", log_b[1], pb1);
        // R7: idle lines stay put, no second sequence from a mid-run start
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R7 idle after run", {4'd0, sh_a, la_a, d_a, dn_a}, 8'b0000_1100);
        end
        check("R7 no extra latch", 8'(lat_a + lat_b), 8'd4);
    endtask

    initial begin
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 20000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed, gap, pos;
        seed = $urandom(32'd715);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset lines", {4'd0, sh_a, la_a, d_a, dn_a}, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {4'd0, sh_a, la_a, d_a, dn_a}, 8'd0);
        check("R1 after release alt", {4'd0, sh_b, la_b, d_b, dn_b}, 8'd0);

        // directed: clean run from reset state, latch starts low
        run_seq(-1, 1'b0);
        // directed corner: start in the very last cycle before the final latch edge
        run_seq(TOTAL - 1, 1'b1);
        // directed corner: start one cycle after acceptance
        run_seq(0, 1'b1);
        // random mid-run starts and idle gaps
        for (int n = 0; n < 4; n++) begin
            gap = 1 + int'($urandom % 12);
            repeat (gap) @(negedge clk);
            pos = 1 + int'($urandom % (TOTAL - 2));
            run_seq(pos, 1'b1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule